// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a programmable integer N. It does not use one wide modulo counter. It models a two-ratio prescaler that runs at either P or P+1 input cycles per output tick. A main counter (B) and a swallow counter (A) steer that prescaler, so the total ratio is N = B·P + A. The output is a single-cycle pulse once per N input cycles, meant to feed a phase comparator.

At the start of every output period both counters reload. The prescaler then runs at P+1 while the swallow count is non-zero, and at P for the rest of the main count. The pulse is raised when the main count runs out.

New settings are written into a holding register with a load strobe. They are copied into the counters only at the next output-period boundary, so a period never mixes two settings. A setting that would break the ratio formula is refused and flagged.

Top module: `pswallow_divider`

## Requirements
- R1: With prescaler select 0, 1 or 2 (P = 8, 16 or 32), B and A, the rising edges of `divOut` are exactly B·P + A input cycles apart.
- R2: `divOut` is high for exactly one input cycle per output period.
- R3: A load with select 3, with B below 3, or with A greater than B is refused. `cfgInvalid` is high for exactly the one cycle after the strobe edge. Neither the output period nor any earlier accepted pending setting changes.
- R4: An accepted load first governs the output period that starts at the first `divOut` pulse registered on a clock edge later than the strobe edge. A strobe on the same edge as a pulse is deferred to the following period.
- R5: When several accepted loads arrive before one boundary, only the last one takes effect.
- R6: In every output period `modHigh` (the prescaler modulus control, 1 = P+1) is high for the first A·(P+1) cycles and low for the remaining B·P − A·P cycles.
- R7: Synchronous reset clears both counters, drives `divOut` and `cfgInvalid` low and sets `modHigh` high. After reset the ratio is B = 16, A = 0, P = 8 (N = 128).
- R8: The corner settings A = B (every prescaler period at P+1) and B = 3 (minimum) are accepted and give N = B·P + A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| loadStb | input | 1 | One-cycle strobe that captures `preSel`, `bLoad`, `aLoad` |
| preSel | input | 2 | Prescaler pair: 0 = 8/9, 1 = 16/17, 2 = 32/33, 3 = illegal |
| bLoad | input | 13 | Main counter value B |
| aLoad | input | 5 | Swallow counter value A |
| divOut | output | 1 | One-cycle pulse per N input cycles |
| modHigh | output | 1 | Prescaler modulus control, 1 while dividing by P+1 |
| cfgInvalid | output | 1 | Pulses for one cycle after a refused load |

## Verification
The bench aims a load at the exact edge on which a period ends. A design that reloads from the holding register on that edge would produce one period of the new length a period too early. It sends two accepted loads inside one period; keeping the first instead of the last shows up as a wrong period length. It sends refused settings, including one while a valid setting is still pending; leaking them into the holding register changes the measured period or disturbs the pending value. The high time of the modulus control is counted in every period, which exposes a swallow counter that runs too long or reloads wrongly, and the corners A = B and B = 3 check the ends of the legal range.

// File: rtl/pswd_pkg.sv
package pswd_pkg;

  // Width of the prescaler down-counter, sized for the largest modulus (33).
  localparam int PRE_W = $clog2(33);

  // Strobes passed from the control half to the counting half.
  typedef struct packed {
    logic tick;      // prescaler period ends this cycle
    logic endCycle;  // main count ends: raise the output pulse
    logic reload;    // reload both counters (end of period or first start)
  } dpStrobe_t;

  // Lower modulus P for a select code; code 3 is refused before it gets here.
  function automatic logic [PRE_W-1:0] lowModulus(input logic [1:0] sel);
    case (sel)
      2'd0:    lowModulus = PRE_W'(8);
      2'd1:    lowModulus = PRE_W'(16);
      default: lowModulus = PRE_W'(32);
    endcase
  endfunction

endpackage

// File: rtl/pswd_ctrl.sv
module pswd_ctrl
  import pswd_pkg::*;
#(
  parameter int BW     = 13,
  parameter int AW     = 5,
  parameter int MinB   = 3,
  parameter int DefB   = 16,
  parameter int DefA   = 0,
  parameter int DefSel = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadStb,
  input  logic [1:0]       selIn,
  input  logic [BW-1:0]    bIn,
  input  logic [AW-1:0]    aIn,
  input  logic             preZero,
  input  logic             bIsOne,
  input  logic             bIsZero,
  output dpStrobe_t        strobe,
  output logic [BW-1:0]    rldB,
  output logic [AW-1:0]    rldA,
  output logic [PRE_W-1:0] rldP,
  output logic             cfgInvalid
);

  logic          cfgOk, acceptLd;
  logic [BW-1:0] actB, pendB;
  logic [AW-1:0] actA, pendA;
  logic [1:0]    actSel, pendSel;
  logic          pendV;

  // Legal setting: a real prescaler pair, B at least the minimum, A not above B.
  assign cfgOk = (selIn != 2'd3) && (bIn >= BW'(MinB)) &&
                 ({{(BW-AW){1'b0}}, aIn} <= bIn);
  assign acceptLd = loadStb && cfgOk;

  assign strobe.tick     = preZero;
  assign strobe.endCycle = preZero && bIsOne;
  assign strobe.reload   = preZero && (bIsOne || bIsZero);

  // Values that the counters take on the next reload.
  assign rldB = pendV ? pendB : actB;
  assign rldA = pendV ? pendA : actA;
  assign rldP = lowModulus(pendV ? pendSel : actSel);

  always_ff @(posedge clk) begin
    if (rst) begin
      actB       <= BW'(DefB);
      actA       <= AW'(DefA);
      actSel     <= 2'(DefSel);
      pendB      <= '0;
      pendA      <= '0;
      pendSel    <= '0;
      pendV      <= 1'b0;
      cfgInvalid <= 1'b0;
    end else begin
      cfgInvalid <= loadStb && !cfgOk;
      if (acceptLd) begin
        pendB   <= bIn;
        pendA   <= aIn;
        pendSel <= selIn;
      end
      // A new accepted load wins over the reload that consumes the old one.
      pendV <= acceptLd || (pendV && !strobe.reload);
      if (strobe.reload && pendV) begin
        actB   <= pendB;
        actA   <= pendA;
        actSel <= pendSel;
      end
    end
  end

  // R3: a refused load never arms the holding register.
  a_r3_refused_not_pending: assert property (@(posedge clk) disable iff (rst)
    (loadStb && !cfgOk && !pendV) |=> !pendV);

  // R3: the refusal flag only follows a strobe.
  a_r3_flag_after_strobe: assert property (@(posedge clk) disable iff (rst)
    cfgInvalid |-> $past(loadStb));

  // R4: the active setting moves only on a period boundary.
  a_r4_active_at_boundary: assert property (@(posedge clk) disable iff (rst)
    !strobe.reload |=> ($stable(actB) && $stable(actA) && $stable(actSel)));

endmodule

// File: rtl/pswd_dp.sv
module pswd_dp
  import pswd_pkg::*;
#(
  parameter int BW = 13,
  parameter int AW = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        strobe,
  input  logic [BW-1:0]    rldB,
  input  logic [AW-1:0]    rldA,
  input  logic [PRE_W-1:0] rldP,
  output logic             preZero,
  output logic             bIsOne,
  output logic             bIsZero,
  output logic             divOut,
  output logic             modHigh
);

  logic [PRE_W-1:0] preCnt, curP;
  logic [BW-1:0]    bCnt;
  logic [AW-1:0]    aCnt, aNext;

  assign preZero = (preCnt == '0);
  assign bIsOne  = (bCnt == BW'(1));
  assign bIsZero = (bCnt == '0);
  // Swallow counter stops at zero; the prescaler then stays at P.
  assign aNext   = (aCnt != '0) ? aCnt - AW'(1) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt  <= '0;
      curP    <= '0;
      bCnt    <= '0;
      aCnt    <= '0;
      modHigh <= 1'b1;
      divOut  <= 1'b0;
    end else begin
      divOut <= strobe.endCycle;
      if (strobe.reload) begin
        bCnt    <= rldB;
        aCnt    <= rldA;
        curP    <= rldP;
        modHigh <= (rldA != '0);
        // Loading P counts P+1 cycles; loading P-1 counts P cycles.
        preCnt  <= (rldA != '0) ? rldP : rldP - PRE_W'(1);
      end else if (strobe.tick) begin
        bCnt    <= bCnt - BW'(1);
        aCnt    <= aNext;
        modHigh <= (aNext != '0);
        preCnt  <= (aNext != '0) ? curP : curP - PRE_W'(1);
      end else begin
        preCnt <= preCnt - PRE_W'(1);
      end
    end
  end

  // R2: the output pulse lasts a single cycle.
  a_r2_single_cycle: assert property (@(posedge clk) disable iff (rst)
    divOut |=> !divOut);

  // R1: the swallow count never exceeds the main count.
  a_r1_swallow_bounded: assert property (@(posedge clk) disable iff (rst)
    ({{(BW-AW){1'b0}}, aCnt} <= bCnt));

  // R7: the modulus control leaves reset at P+1.
  a_r7_mod_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> modHigh);

  // R2: a pulse is raised only after the main count has run out.
  a_r2_pulse_at_expiry: assert property (@(posedge clk) disable iff (rst)
    divOut |-> (bCnt != '0));

endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider
  import pswd_pkg::*;
#(
  parameter int BW     = 13,
  parameter int AW     = 5,
  parameter int MinB   = 3,
  parameter int DefB   = 16,
  parameter int DefA   = 0,
  parameter int DefSel = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          loadStb,
  input  logic [1:0]    preSel,
  input  logic [BW-1:0] bLoad,
  input  logic [AW-1:0] aLoad,
  output logic          divOut,
  output logic          modHigh,
  output logic          cfgInvalid
);

  dpStrobe_t        strobe;
  logic [BW-1:0]    rldB;
  logic [AW-1:0]    rldA;
  logic [PRE_W-1:0] rldP;
  logic             preZero, bIsOne, bIsZero;

  pswd_ctrl #(
    .BW(BW), .AW(AW), .MinB(MinB), .DefB(DefB), .DefA(DefA), .DefSel(DefSel)
  ) uCtrl (
    .clk(clk), .rst(rst), .loadStb(loadStb), .selIn(preSel),
    .bIn(bLoad), .aIn(aLoad), .preZero(preZero), .bIsOne(bIsOne),
    .bIsZero(bIsZero), .strobe(strobe), .rldB(rldB), .rldA(rldA),
    .rldP(rldP), .cfgInvalid(cfgInvalid)
  );

  pswd_dp #(.BW(BW), .AW(AW)) uDp (
    .clk(clk), .rst(rst), .strobe(strobe), .rldB(rldB), .rldA(rldA),
    .rldP(rldP), .preZero(preZero), .bIsOne(bIsOne), .bIsZero(bIsZero),
    .divOut(divOut), .modHigh(modHigh)
  );

endmodule

// File: tb/sim_pswallow_divider.sv
module sim_pswallow_divider;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadStb = 1'b0;
  logic [1:0]  preSel = '0;
  logic [12:0] bLoad = '0;
  logic [4:0]  aLoad = '0;
  logic        divOut, modHigh, cfgInvalid;

  pswallow_divider u0 (
    .clk(clk), .rst(rst), .loadStb(loadStb), .preSel(preSel),
    .bLoad(bLoad), .aLoad(aLoad), .divOut(divOut), .modHigh(modHigh),
    .cfgInvalid(cfgInvalid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit ok;
    int n;
    int hi;
  } ldItem_t;

  ldItem_t ldQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic ldItem_t predict(int sel, int b, int a);
    ldItem_t it;
    int p;
    p = 8 << sel;
    it.ok = (sel != 3) && (b >= 3) && (a <= b);
    it.n  = b * p + a;
    it.hi = a * (p + 1);
    return it;
  endfunction

  task automatic check(bit good, string req, int act, int exp);
    checks++;
    if (!good) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Driver: called right at a posedge; the strobe is sampled on the next one.
  task automatic doLoad(int sel, int b, int a);
    ldQ.push_back(predict(sel, b, a));
    #1;
    preSel  = 2'(sel);
    bLoad   = 13'(b);
    aLoad   = 5'(a);
    loadStb = 1'b1;
    @(posedge clk);
    #1 loadStb = 1'b0;
  endtask

  task automatic afterPulse(int k);
    @(posedge divOut);
    repeat (k) @(posedge clk);
  endtask

  task automatic waitPulses(int k);
    repeat (k) @(posedge divOut);
  endtask

  // Monitor / scoreboard
  ldItem_t cur, pend, stage;
  bit pendV, stageV, first, prevDiv;
  int cnt, hiCnt;

  always @(negedge clk) begin
    if (rst) begin
      cur = '{1'b1, 128, 0};  // R7 defaults: B=16, A=0, P=8
      pendV = 0; stageV = 0; first = 1; prevDiv = 0; cnt = 0; hiCnt = 0;
    end else begin
      // R3: refusal flag one cycle after the strobe edge
      if ((stageV && !stage.ok) || cfgInvalid)
        check(cfgInvalid == (stageV && !stage.ok), "R3 cfgInvalid",
              int'(cfgInvalid), int'(stageV && !stage.ok));
      cnt++;
      if (divOut) begin
        check(!prevDiv, "R2 pulse width", int'(prevDiv), 0);
        if (!first) begin
          check(cnt == cur.n, "R1/R4/R5 period", cnt, cur.n);
          check(hiCnt == cur.hi, "R6 modHigh cycles", hiCnt, cur.hi);
        end
        first = 0;
        cnt = 0;
        if (pendV) begin
          cur = pend;
          pendV = 0;
        end
        hiCnt = int'(modHigh);
      end else begin
        hiCnt += int'(modHigh);
      end
      prevDiv = divOut;
      if (stageV && stage.ok) begin
        pend = stage;
        pendV = 1;
      end
      stageV = 0;
      if (loadStb) begin
        stage = ldQ.pop_front();
        stageV = 1;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R7: reset state at the ports
    check(divOut == 1'b0, "R7 divOut in reset", int'(divOut), 0);
    check(modHigh == 1'b1, "R7 modHigh in reset", int'(modHigh), 1);
    check(cfgInvalid == 1'b0, "R7 cfgInvalid in reset", int'(cfgInvalid), 0);
    rst = 1'b0;
    waitPulses(3);                 // R7 default N=128
    afterPulse(0); doLoad(0, 3, 3);   // R8: A=B, B=3 -> 27
    waitPulses(3);
    afterPulse(2); doLoad(1, 5, 2);   // R1: P=16 -> 82
    waitPulses(3);
    afterPulse(0); doLoad(2, 4, 1);   // R1: P=32 -> 129
    waitPulses(2);
    afterPulse(5); doLoad(0, 4, 5);   // R3: A>B refused
    doLoad(0, 2, 0);                  // R3: B below minimum
    doLoad(3, 10, 0);                 // R3: select 3
    waitPulses(2);
    afterPulse(1); doLoad(0, 3, 0);   // R5: overwritten
    doLoad(0, 10, 7);                 // R5: this one wins -> 87
    waitPulses(3);
    afterPulse(86); doLoad(1, 3, 1);  // R4: strobe on the boundary edge -> 49 deferred
    waitPulses(3);
    afterPulse(0); doLoad(0, 6, 6);   // R3: valid 54 pending...
    doLoad(0, 5, 6);                  // ...refused load must not disturb it
    waitPulses(3);
    afterPulse(3); doLoad(0, 31, 31); // R8: largest A with A=B -> 279
    waitPulses(3);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule